// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup

This block holds renamed instructions until their source operands are available and then hands them to execution, oldest first. Each dispatched instruction brings an operation class, up to two source physical registers, an optional destination physical register and a 16-bit sequence number. A per-register scoreboard decides at insert time whether each source is already available. Sources that are not yet available wait for a completion broadcast of their register tag. One broadcast wakes every entry that waits on that tag.

Each cycle the queue offers up to a fixed total number of ready instructions on its issue slots. Integer, floating-point and branch instructions each have their own per-cycle limit, and a shared total limit applies on top. A squash carrying a sequence number discards every queued instruction younger than that number. The physical register space is flat: integer registers take the low indices and floating-point registers follow directly after them.

Top module: `issue_queue`

## Requirements
- R1: After reset the queue is empty: free_count equals ENTRIES (16), full is 0 and no issue slot is valid.
- R2: A dispatch is accepted only when the queue has a free entry and no squash is requested in that cycle. Each accepted dispatch lowers free_count by one. full is 1 exactly when free_count is 0. A dispatch presented while full is dropped and changes neither free_count nor the issue slots.
- R3: Every scoreboard bit is 1 after reset. A bit is cleared when an instruction that writes that register is accepted, and set when the register's tag is broadcast. A source whose bit is 1 at insert is ready at once, and its instruction can issue in the next cycle.
- R4: A broadcast in the same cycle as an insert whose source names the broadcast tag marks that source ready, so the instruction can issue in the next cycle.
- R5: A broadcast on wake_tag marks ready every queued source that waits on that tag. The woken instructions become issuable in the cycle after the broadcast.
- R6: Class codes are 0 integer, 1 floating point and 2 branch. At most 2 integer, 1 floating-point and 1 branch instruction issue per cycle, and within a class the oldest ready instructions are chosen.
- R7: At most 3 instructions issue per cycle in total. The instructions chosen by their classes are ranked by age across classes: slot 0 carries the oldest, and slot k is valid only if slot k-1 is valid and holds an older instruction.
- R8: Age is judged by 16-bit wraparound subtraction: a is older than b when bit 15 of (a - b) is 1. For example, 0xFFFE is older than 0x0002.
- R9: A squash removes every queued instruction whose sequence number is younger than squash_seq. Instructions with an equal or older sequence number stay queued.
- R10: In a squash cycle no issue slot is valid and no dispatch is accepted.
- R11: An instruction shown on an issue slot leaves the queue at the end of that cycle. free_count in the next cycle rises by the number of instructions issued, less any instruction inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_cls | input | 2 | Operation class of the dispatched instruction |
| disp_src0_valid | input | 1 | First source present |
| disp_src0 | input | PREG_W (6) | First source physical register |
| disp_src1_valid | input | 1 | Second source present |
| disp_src1 | input | PREG_W (6) | Second source physical register |
| disp_dst_valid | input | 1 | Destination present |
| disp_dst | input | PREG_W (6) | Destination physical register |
| disp_seq | input | 16 | Sequence number |
| wake_valid | input | 1 | Completion broadcast |
| wake_tag | input | PREG_W (6) | Register produced |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | 16 | Younger than this is removed |
| iss_valid | output | TOTAL_W (3) | Issue slot valid |
| iss_cls | output | 2*TOTAL_W | Class per slot |
| iss_seq | output | 16*TOTAL_W | Sequence number per slot |
| iss_dst_valid | output | TOTAL_W | Destination present per slot |
| iss_dst | output | PREG_W*TOTAL_W | Destination per slot |
| free_count | output | CNT_W (5) | Number of free entries |
| full | output | 1 | No free entry |

## Verification
Two pairs of functions can meet in one cycle. A completion broadcast can land in the same cycle as an insert that reads the broadcast register. The bench drives both together and then expects the new instruction on slot 0 one cycle later; without the bypass it would never issue. A squash can also meet both a ready entry and a new dispatch. The bench judges that cycle by expecting all slots idle, then checks in the next cycle that free_count reflects only the survivors and that the older ready instruction issues.

// File: rtl/iq_pkg.sv
// Shared types and helpers for the issue queue.
// Assumes sequence numbers are unique among live entries.
package iq_pkg;
    localparam int SEQ_W = 16;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_FP  = 2'd1,
        CLS_BR  = 2'd2
    } iq_cls_e;

    // True when sequence number a was allocated before b (wrap-safe).
    function automatic logic seq_older(input logic [SEQ_W-1:0] a,
                                       input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction
endpackage

// File: rtl/iq_scoreboard.sv
// Per-register produced bit with bypass on the read path.
// A read returns 1 if the stored bit is set or if the same register is
// broadcast in this cycle. When set and clear hit the same register in
// one cycle, the clear wins, because it marks a new producer.
module iq_scoreboard #(
    parameter int NUM_REGS = 64,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] rd_idx0,
    input  logic [IDX_W-1:0] rd_idx1,
    output logic             rd_rdy0,
    output logic             rd_rdy1
);
    logic [NUM_REGS-1:0] done_q;

    // Track produced state: all registers start produced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '1;
        end else begin
            if (set_en) done_q[set_idx] <= 1'b1;
            if (clr_en) done_q[clr_idx] <= 1'b0;
        end
    end

    // Read ports with same-cycle broadcast bypass.
    always_comb begin
        rd_rdy0 = done_q[rd_idx0] | (set_en && (set_idx == rd_idx0));
        rd_rdy1 = done_q[rd_idx1] | (set_en && (set_idx == rd_idx1));
    end
endmodule

// File: rtl/iq_alloc.sv
// Free-entry finder: picks the lowest free index and counts the free entries.
// Assumes ENTRIES >= 2.
module iq_alloc #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input  logic [ENTRIES-1:0] vld,
    output logic [IDX_W-1:0]   free_idx,
    output logic               has_free,
    output logic [CNT_W-1:0]   free_count
);
    // Lowest free slot and free count.
    always_comb begin
        free_idx   = '0;
        has_free   = 1'b0;
        free_count = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!vld[e]) begin
                free_idx   = IDX_W'(e);
                has_free   = 1'b1;
                free_count = free_count + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/iq_select.sv
// Oldest-first selector with per-class and total limits.
// An entry qualifies in its class when fewer than the class limit of ready
// same-class entries are older than it. Qualified entries are then ranked
// by age, and the TOTAL_W oldest are granted; slot k carries rank k.
module iq_select import iq_pkg::*; #(
    parameter int ENTRIES = 16,
    parameter int INT_W   = 2,
    parameter int FP_W    = 1,
    parameter int BR_W    = 1,
    parameter int TOTAL_W = 3,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input  logic [ENTRIES-1:0]            rdy,
    input  logic [ENTRIES-1:0][1:0]       cls,
    input  logic [ENTRIES-1:0][SEQ_W-1:0] seq,
    output logic [ENTRIES-1:0]            grant,
    output logic [TOTAL_W-1:0]            slot_vld,
    output logic [TOTAL_W-1:0][IDX_W-1:0] slot_idx
);
    logic [ENTRIES-1:0]            elig;
    logic [ENTRIES-1:0][CNT_W-1:0] rank;

    // Per-class issue limit; unused class codes never issue.
    function automatic logic [CNT_W-1:0] cls_limit(input logic [1:0] c);
        case (c)
            CLS_INT: return CNT_W'(INT_W);
            CLS_FP:  return CNT_W'(FP_W);
            CLS_BR:  return CNT_W'(BR_W);
            default: return '0;
        endcase
    endfunction

    // Class-level qualification: count older ready peers of the same class.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            logic [CNT_W-1:0] peers;
            peers = '0;
            for (int o = 0; o < ENTRIES; o++) begin
                if (o != e && rdy[o] && cls[o] == cls[e] && seq_older(seq[o], seq[e]))
                    peers = peers + CNT_W'(1);
            end
            elig[e] = rdy[e] && (peers < cls_limit(cls[e]));
        end
    end

    // Global age rank among qualified entries, then grant under the total cap.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            rank[e] = '0;
            for (int o = 0; o < ENTRIES; o++) begin
                if (o != e && elig[o] && seq_older(seq[o], seq[e]))
                    rank[e] = rank[e] + CNT_W'(1);
            end
            grant[e] = elig[e] && (rank[e] < CNT_W'(TOTAL_W));
        end
    end

    // Map each granted entry onto the slot given by its rank.
    always_comb begin
        for (int k = 0; k < TOTAL_W; k++) begin
            slot_vld[k] = 1'b0;
            slot_idx[k] = '0;
            for (int e = 0; e < ENTRIES; e++) begin
                if (grant[e] && rank[e] == CNT_W'(k)) begin
                    slot_vld[k] = 1'b1;
                    slot_idx[k] = IDX_W'(e);
                end
            end
        end
    end
endmodule

// File: rtl/issue_queue.sv
// Issue queue top: entry storage, tag wakeup, squash, and issue slot muxing.
// Assumes unique live sequence numbers and at most one dispatch and one
// broadcast per cycle. Squash outranks insert and issue in the same cycle.
// Register space is flat: integer registers first, floating point after.
module issue_queue import iq_pkg::*; #(
    parameter int ENTRIES  = 16,
    parameter int INT_REGS = 32,
    parameter int FP_REGS  = 32,
    parameter int INT_W    = 2,
    parameter int FP_W     = 1,
    parameter int BR_W     = 1,
    parameter int TOTAL_W  = 3,
    localparam int NUM_REGS = INT_REGS + FP_REGS,
    localparam int PREG_W   = $clog2(NUM_REGS),
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int CNT_W    = $clog2(ENTRIES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        disp_valid,
    input  logic [1:0]                  disp_cls,
    input  logic                        disp_src0_valid,
    input  logic [PREG_W-1:0]           disp_src0,
    input  logic                        disp_src1_valid,
    input  logic [PREG_W-1:0]           disp_src1,
    input  logic                        disp_dst_valid,
    input  logic [PREG_W-1:0]           disp_dst,
    input  logic [SEQ_W-1:0]            disp_seq,
    input  logic                        wake_valid,
    input  logic [PREG_W-1:0]           wake_tag,
    input  logic                        squash_valid,
    input  logic [SEQ_W-1:0]            squash_seq,
    output logic [TOTAL_W-1:0]          iss_valid,
    output logic [2*TOTAL_W-1:0]        iss_cls,
    output logic [SEQ_W*TOTAL_W-1:0]    iss_seq,
    output logic [TOTAL_W-1:0]          iss_dst_valid,
    output logic [PREG_W*TOTAL_W-1:0]   iss_dst,
    output logic [CNT_W-1:0]            free_count,
    output logic                        full
);
    logic [ENTRIES-1:0]             vld_q, s0_rdy_q, s1_rdy_q, dstv_q;
    logic [ENTRIES-1:0][1:0]        cls_q;
    logic [ENTRIES-1:0][SEQ_W-1:0]  seq_q;
    logic [ENTRIES-1:0][PREG_W-1:0] s0_q, s1_q, dst_q;

    logic [ENTRIES-1:0]            rdy_vec, grant;
    logic [TOTAL_W-1:0]            slot_vld;
    logic [TOTAL_W-1:0][IDX_W-1:0] slot_idx;
    logic [IDX_W-1:0]              free_idx;
    logic                          has_free, ins, sb_rdy0, sb_rdy1;

    iq_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .vld        (vld_q),
        .free_idx   (free_idx),
        .has_free   (has_free),
        .free_count (free_count)
    );

    // Accept a dispatch only with room and no squash.
    assign ins  = disp_valid && has_free && !squash_valid;
    assign full = !has_free;

    iq_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (ins && disp_dst_valid),
        .clr_idx (disp_dst),
        .set_en  (wake_valid),
        .set_idx (wake_tag),
        .rd_idx0 (disp_src0),
        .rd_idx1 (disp_src1),
        .rd_rdy0 (sb_rdy0),
        .rd_rdy1 (sb_rdy1)
    );

    // An entry requests issue once both sources are ready.
    assign rdy_vec = vld_q & s0_rdy_q & s1_rdy_q;

    iq_select #(
        .ENTRIES (ENTRIES), .INT_W (INT_W), .FP_W (FP_W),
        .BR_W    (BR_W),    .TOTAL_W (TOTAL_W)
    ) u_sel (
        .rdy      (rdy_vec),
        .cls      (cls_q),
        .seq      (seq_q),
        .grant    (grant),
        .slot_vld (slot_vld),
        .slot_idx (slot_idx)
    );

    // Control state: valid and ready bits, with squash, issue, wakeup, insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            s0_rdy_q <= '0;
            s1_rdy_q <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (squash_valid) begin
                    if (vld_q[e] && seq_older(squash_seq, seq_q[e]))
                        vld_q[e] <= 1'b0;
                end else if (grant[e]) begin
                    vld_q[e] <= 1'b0;
                end
                if (wake_valid && s0_q[e] == wake_tag) s0_rdy_q[e] <= 1'b1;
                if (wake_valid && s1_q[e] == wake_tag) s1_rdy_q[e] <= 1'b1;
                if (ins && free_idx == IDX_W'(e)) begin
                    vld_q[e]    <= 1'b1;
                    s0_rdy_q[e] <= !disp_src0_valid || sb_rdy0;
                    s1_rdy_q[e] <= !disp_src1_valid || sb_rdy1;
                end
            end
        end
    end

    // Payload capture on insert; contents are don't-care while invalid.
    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (ins && free_idx == IDX_W'(e)) begin
                cls_q[e]  <= disp_cls;
                seq_q[e]  <= disp_seq;
                s0_q[e]   <= disp_src0;
                s1_q[e]   <= disp_src1;
                dstv_q[e] <= disp_dst_valid;
                dst_q[e]  <= disp_dst;
            end
        end
    end

    // Issue slot drivers, blanked during a squash.
    for (genvar k = 0; k < TOTAL_W; k++) begin : g_slot
        assign iss_valid[k]                    = slot_vld[k] && !squash_valid;
        assign iss_cls[2*k +: 2]               = cls_q[slot_idx[k]];
        assign iss_seq[SEQ_W*k +: SEQ_W]       = seq_q[slot_idx[k]];
        assign iss_dst_valid[k]                = dstv_q[slot_idx[k]];
        assign iss_dst[PREG_W*k +: PREG_W]     = dst_q[slot_idx[k]];
    end
endmodule

// File: rtl/iq_checker.sv
// Protocol checks for the issue queue, bound onto every instance.
module iq_checker import iq_pkg::*; #(
    parameter int ENTRIES = 16,
    parameter int INT_W   = 2,
    parameter int FP_W    = 1,
    parameter int BR_W    = 1,
    parameter int TOTAL_W = 3,
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     disp_valid,
    input logic                     squash_valid,
    input logic                     full,
    input logic [CNT_W-1:0]         free_count,
    input logic [TOTAL_W-1:0]       iss_valid,
    input logic [2*TOTAL_W-1:0]     iss_cls,
    input logic [SEQ_W*TOTAL_W-1:0] iss_seq
);
    logic [CNT_W-1:0] n_int, n_fp, n_br, n_iss;

    // Count issued instructions per class.
    always_comb begin
        n_int = '0; n_fp = '0; n_br = '0; n_iss = '0;
        for (int k = 0; k < TOTAL_W; k++) begin
            if (iss_valid[k]) begin
                n_iss = n_iss + CNT_W'(1);
                case (iss_cls[2*k +: 2])
                    CLS_INT: n_int = n_int + CNT_W'(1);
                    CLS_FP:  n_fp  = n_fp + CNT_W'(1);
                    CLS_BR:  n_br  = n_br + CNT_W'(1);
                    default: ;
                endcase
            end
        end
    end

    AST_CLASS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (n_int <= CNT_W'(INT_W)) && (n_fp <= CNT_W'(FP_W)) && (n_br <= CNT_W'(BR_W))); // R6
    AST_TOTAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        n_iss <= CNT_W'(TOTAL_W)); // R7
    AST_SQUASH_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> (iss_valid == '0)); // R10
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && iss_valid == '0 && !squash_valid) |=> full); // R2
    AST_INSERT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !full && !squash_valid && iss_valid == '0)
        |=> free_count == $past(free_count) - CNT_W'(1)); // R2
    AST_ISSUE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_valid && !squash_valid)
        |=> free_count == $past(free_count) + $past(n_iss)); // R11

    for (genvar k = 1; k < TOTAL_W; k++) begin : g_age
        AST_SLOT_AGE: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k] |-> (iss_valid[k-1] &&
                seq_older(iss_seq[SEQ_W*(k-1) +: SEQ_W], iss_seq[SEQ_W*k +: SEQ_W]))); // R7
    end
endmodule

bind issue_queue iq_checker #(
    .ENTRIES (ENTRIES), .INT_W (INT_W), .FP_W (FP_W),
    .BR_W    (BR_W),    .TOTAL_W (TOTAL_W)
) u_iq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_valid   (disp_valid),
    .squash_valid (squash_valid),
    .full         (full),
    .free_count   (free_count),
    .iss_valid    (iss_valid),
    .iss_cls      (iss_cls),
    .iss_seq      (iss_seq)
);

// File: tb/issue_queue_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module issue_queue_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid, disp_src0_valid, disp_src1_valid, disp_dst_valid;
    logic [1:0] disp_cls;
    logic [5:0] disp_src0, disp_src1, disp_dst, wake_tag;
    logic [15:0] disp_seq, squash_seq;
    logic wake_valid, squash_valid;
    logic [2:0] iss_valid, iss_dst_valid;
    logic [5:0] iss_cls;
    logic [47:0] iss_seq;
    logic [17:0] iss_dst;
    logic [4:0] free_count;
    logic full;
    int nerr = 0;
    int nchk = 0;

    always #2 clk = ~clk;

    issue_queue u_issue_queue (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_cls(disp_cls),
        .disp_src0_valid(disp_src0_valid), .disp_src0(disp_src0),
        .disp_src1_valid(disp_src1_valid), .disp_src1(disp_src1),
        .disp_dst_valid(disp_dst_valid), .disp_dst(disp_dst), .disp_seq(disp_seq),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_seq(iss_seq),
        .iss_dst_valid(iss_dst_valid), .iss_dst(iss_dst),
        .free_count(free_count), .full(full)
    );

    typedef struct packed {
        logic        dv;
        logic [1:0]  cls;
        logic        s0v;
        logic [5:0]  s0;
        logic        dstv;
        logic [5:0]  dst;
        logic [15:0] seq;
        logic        wv;
        logic [5:0]  wt;
        logic [4:0]  exp_free;
        logic [2:0]  exp_mask;
        logic [15:0] exp_seq0;
    } vec_t;

    // Scoreboard-at-insert (R3) and wakeup (R5) sequence.
    localparam vec_t VEC [10] = '{
        '{1'b1, 2'd0, 1'b1, 6'd5, 1'b1, 6'd6,  16'd10, 1'b0, 6'd0, 5'd16, 3'b000, 16'd0},
        '{1'b1, 2'd0, 1'b1, 6'd6, 1'b1, 6'd7,  16'd11, 1'b0, 6'd0, 5'd15, 3'b001, 16'd10},
        '{1'b0, 2'd0, 1'b0, 6'd0, 1'b0, 6'd0,  16'd0,  1'b0, 6'd0, 5'd15, 3'b000, 16'd0},
        '{1'b0, 2'd0, 1'b0, 6'd0, 1'b0, 6'd0,  16'd0,  1'b1, 6'd6, 5'd15, 3'b000, 16'd0},
        '{1'b0, 2'd0, 1'b0, 6'd0, 1'b0, 6'd0,  16'd0,  1'b0, 6'd0, 5'd15, 3'b001, 16'd11},
        '{1'b1, 2'd1, 1'b1, 6'd7, 1'b1, 6'd40, 16'd12, 1'b0, 6'd0, 5'd16, 3'b000, 16'd0},
        '{1'b0, 2'd0, 1'b0, 6'd0, 1'b0, 6'd0,  16'd0,  1'b0, 6'd0, 5'd15, 3'b000, 16'd0},
        '{1'b0, 2'd0, 1'b0, 6'd0, 1'b0, 6'd0,  16'd0,  1'b1, 6'd7, 5'd15, 3'b000, 16'd0},
        '{1'b0, 2'd0, 1'b0, 6'd0, 1'b0, 6'd0,  16'd0,  1'b0, 6'd0, 5'd15, 3'b001, 16'd12},
        '{1'b0, 2'd0, 1'b0, 6'd0, 1'b0, 6'd0,  16'd0,  1'b0, 6'd0, 5'd16, 3'b000, 16'd0}
    };

    task automatic clear_in();
        disp_valid = 0; disp_cls = 0; disp_src0_valid = 0; disp_src0 = 0;
        disp_src1_valid = 0; disp_src1 = 0; disp_dst_valid = 0; disp_dst = 0;
        disp_seq = 0; wake_valid = 0; wake_tag = 0; squash_valid = 0; squash_seq = 0;
    endtask

    task automatic next();
        @(posedge clk); #1; clear_in();
    endtask

    task automatic put(input int cls, input int s0v, input int s0, input int dstv,
                       input int dst, input int seq);
        disp_valid = 1; disp_cls = 2'(cls);
        disp_src0_valid = 1'(s0v); disp_src0 = 6'(s0);
        disp_src1_valid = 1; disp_src1 = 6'd5;
        disp_dst_valid = 1'(dstv); disp_dst = 6'(dst); disp_seq = 16'(seq);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sseq(input int k);
        return int'(iss_seq[k*16 +: 16]);
    endfunction

    // Make a register busy: insert a producer for it and let it issue.
    task automatic make_busy(input int r, input int seq);
        put(0, 0, 0, 1, r, seq); next(); next();
    endtask

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R1", "free after reset", int'(free_count), 16);
        chk("R1", "full after reset", int'(full), 0);
        chk("R1", "issue after reset", int'(iss_valid), 0);

        // Vector table: R3 scoreboard at insert, R5 wakeup timing.
        for (int i = 0; i < 10; i++) begin
            disp_valid = VEC[i].dv; disp_cls = VEC[i].cls;
            disp_src0_valid = VEC[i].s0v; disp_src0 = VEC[i].s0;
            disp_dst_valid = VEC[i].dstv; disp_dst = VEC[i].dst; disp_seq = VEC[i].seq;
            wake_valid = VEC[i].wv; wake_tag = VEC[i].wt;
            #1;
            chk("R3", $sformatf("vec %0d free", i), int'(free_count), int'(VEC[i].exp_free));
            chk("R5", $sformatf("vec %0d mask", i), int'(iss_valid), int'(VEC[i].exp_mask));
            if (VEC[i].exp_mask[0])
                chk("R5", $sformatf("vec %0d slot0", i), sseq(0), int'(VEC[i].exp_seq0));
            next();
        end

        // R6 and R7: class limits, total cap, age order across classes.
        make_busy(10, 1);
        put(0, 1, 10, 0, 0, 23); next();
        put(0, 1, 10, 0, 0, 21); next();
        put(0, 1, 10, 0, 0, 22); next();
        put(0, 1, 10, 0, 0, 20); next();
        put(1, 1, 10, 0, 0, 25); next();
        put(1, 1, 10, 0, 0, 24); next();
        put(2, 1, 10, 0, 0, 27); next();
        put(2, 1, 10, 0, 0, 26); next();
        wake_valid = 1; wake_tag = 6'd10; #1;
        chk("R5", "no issue in wake cycle", int'(iss_valid), 0);
        next(); #1;
        chk("R7", "cycle A mask", int'(iss_valid), 7);
        chk("R6", "cycle A slot0", sseq(0), 20);
        chk("R6", "cycle A slot1", sseq(1), 21);
        chk("R7", "cycle A slot2", sseq(2), 24);
        chk("R2", "cycle A free", int'(free_count), 8);
        next(); #1;
        chk("R7", "cycle B mask", int'(iss_valid), 7);
        chk("R6", "cycle B slot0", sseq(0), 22);
        chk("R6", "cycle B slot1", sseq(1), 23);
        chk("R6", "cycle B slot2", sseq(2), 25);
        chk("R11", "cycle B free", int'(free_count), 11);
        next(); #1;
        chk("R6", "cycle C mask", int'(iss_valid), 1);
        chk("R6", "cycle C branch", sseq(0), 26);
        next(); #1;
        chk("R6", "cycle D branch", sseq(0), 27);
        next(); #1;
        chk("R11", "drained free", int'(free_count), 16);

        // R4: broadcast in the insert cycle.
        make_busy(12, 40);
        put(0, 1, 12, 0, 0, 41); wake_valid = 1; wake_tag = 6'd12; #1;
        chk("R4", "insert cycle mask", int'(iss_valid), 0);
        next(); #1;
        chk("R4", "bypassed issue mask", int'(iss_valid), 1);
        chk("R4", "bypassed issue seq", sseq(0), 41);
        next();

        // R9 and R10: squash with a ready entry and a dispatch in the same cycle.
        make_busy(13, 50);
        put(0, 1, 13, 0, 0, 100); next();
        put(0, 1, 13, 0, 0, 101); next();
        put(0, 1, 13, 0, 0, 102); next();
        put(0, 1, 13, 0, 0, 103); next();
        put(0, 0, 0, 0, 0, 90); next();
        put(0, 0, 0, 0, 0, 104); squash_valid = 1; squash_seq = 16'd101; #1;
        chk("R10", "no issue during squash", int'(iss_valid), 0);
        chk("R2", "free before squash", int'(free_count), 11);
        next();
        wake_valid = 1; wake_tag = 6'd13; #1;
        chk("R9", "free after squash", int'(free_count), 13);
        chk("R10", "survivor issues", sseq(0), 90);
        next(); #1;
        chk("R9", "kept entries mask", int'(iss_valid), 3);
        chk("R9", "kept slot0", sseq(0), 100);
        chk("R9", "kept slot1", sseq(1), 101);
        next(); #1;
        chk("R11", "free after squash drain", int'(free_count), 16);

        // R8: wraparound age order and wraparound squash.
        make_busy(14, 60);
        put(0, 1, 14, 0, 0, 16'h0002); next();
        put(0, 1, 14, 0, 0, 16'hFFFE); next();
        wake_valid = 1; wake_tag = 6'd14; next(); #1;
        chk("R8", "wrap mask", int'(iss_valid), 3);
        chk("R8", "wrap slot0", sseq(0), 16'hFFFE);
        chk("R8", "wrap slot1", sseq(1), 16'h0002);
        next();
        make_busy(16, 61);
        put(0, 1, 16, 0, 0, 16'hFFFE); next();
        put(0, 1, 16, 0, 0, 16'h0001); next();
        squash_valid = 1; squash_seq = 16'hFFFF; next(); #1;
        chk("R8", "wrap squash free", int'(free_count), 15);
        wake_valid = 1; wake_tag = 6'd16; next(); #1;
        chk("R9", "wrap survivor", sseq(0), 16'hFFFE);
        chk("R9", "wrap survivor mask", int'(iss_valid), 1);
        next();

        // R2: fill, reject while full, then squash everything.
        make_busy(15, 70);
        for (int s = 200; s < 216; s++) begin
            put(0, 1, 15, 0, 0, s); next();
        end
        #1;
        chk("R2", "full flag", int'(full), 1);
        chk("R2", "free at full", int'(free_count), 0);
        put(0, 0, 0, 0, 0, 216); #1;
        chk("R2", "no issue while full", int'(iss_valid), 0);
        next(); #1;
        chk("R2", "dispatch dropped free", int'(free_count), 0);
        chk("R2", "dispatch dropped issue", int'(iss_valid), 0);
        squash_valid = 1; squash_seq = 16'd199; next(); #1;
        chk("R9", "squash all free", int'(free_count), 16);
        chk("R2", "not full after squash", int'(full), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule